// File: doc/BRIEF.md
# Scroll and Video Address Register Unit

This unit keeps the scroll position and the video memory address for a tile-based video controller. It holds a 15-bit live address, a 15-bit staging latch, a 3-bit fine horizontal offset and a single phase bit. The phase bit is shared by the scroll port and the address port, and each of those ports takes a pair of byte writes. The processor writes bytes at small register offsets. Each offset places its bits into the staging latch in its own way. Some writes also load the fine offset, and the second address byte moves the whole latch into the live address.

On the display side, the unit watches a rendering-enable flag, the line counter, the dot counter and a flag that marks the line before the first visible line. At two fixed dots it copies parts of the staging latch into the live address. One copy restores the horizontal position on every line. The other reloads the full address once per frame. The logic that steps the live address during a line is not part of this unit.

Field layout of the latch and the live address: bits 14..12 hold the fine vertical offset, bits 11..10 the page select, bits 9..5 the coarse vertical tile and bits 4..0 the coarse horizontal tile.

Top module: `scroll_addr_unit`

## Requirements
- R1: After reset the live address, the latch, the fine offset and the phase bit are all zero.
- R2: Writes at offset 5 and at offset 6 share one phase bit. Every such write inverts it, and phase 0 selects first-byte behaviour. A read strobe at offset 2 clears the phase bit. A write at offset 0 leaves the phase bit unchanged.
- R3: A write at offset 5 in phase 0 loads the fine offset from data[2:0] in the next cycle, loads latch[4:0] from data[7:3], and leaves the live address unchanged.
- R4: A write at offset 5 in phase 1 loads latch[14:12] from data[2:0] and latch[9:5] from data[7:3], and leaves the live address unchanged.
- R5: A write at offset 6 in phase 0 clears latch[14] and loads latch[13:8] from data[5:0]. Data bits 7..6 have no effect.
- R6: A write at offset 6 in phase 1 loads latch[7:0] from the data byte. The live address then equals the updated latch on the following cycle.
- R7: A write at offset 0 loads latch[11:10] from data[1:0].
- R8: When rendering is enabled, the live address takes the whole latch at dot 304 of the pre-render line.
- R9: When rendering is enabled, at dot 257 of each visible line (line < 240) and of the pre-render line, live bits 10 and 4..0 take the latch values, and the other live bits are kept.
- R10: No copy happens when rendering is disabled. No copy happens on a line that is neither visible nor pre-render.
- R11: A timing copy uses the latch value held before any write in the same cycle. A second address byte in the same cycle as a copy takes priority over the copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe |
| cpu_offs | input | 3 | Register offset |
| cpu_wdata | input | 8 | Write data byte |
| render_en | input | 1 | Background or sprite rendering enabled |
| scanline | input | 9 | Current line number |
| dot | input | 9 | Current dot within the line |
| prerender | input | 1 | Current line is the pre-render line |
| vaddr_o | output | 15 | Live video address |
| fine_x_o | output | 3 | Fine horizontal offset |

## Verification
The latch cannot be read directly, so the hardest case is showing that each latch field was placed correctly. The bench does this by triggering a full-frame copy, which brings the latch out on the live address, and by triggering a per-line copy, which exposes only the horizontal bits. The phase bit is also hidden. Its state is inferred from whether the next offset-5 write changes the fine offset, with status reads and control writes placed between the byte pairs. Cycles where a write and a copy happen together are driven on purpose to exercise the priority rules.

// File: rtl/scroll_pkg.sv
// Shared constants and types for the scroll/address unit.
// Assumes the fixed 15-bit field layout described in the brief.
package scroll_pkg;
    localparam int ADDR_W = 15;
    localparam int FINE_W = 3;
    localparam int DATA_W = 8;
    localparam int OFFS_W = 3;

    localparam logic [OFFS_W-1:0] OFFS_CTRL = 3'd0;
    localparam logic [OFFS_W-1:0] OFFS_STAT = 3'd2;
    localparam logic [OFFS_W-1:0] OFFS_SCRL = 3'd5;
    localparam logic [OFFS_W-1:0] OFFS_ADDR = 3'd6;

    // Bits restored by the per-line horizontal copy.
    localparam logic [ADDR_W-1:0] HORIZ_MASK = 15'h041F;

    typedef logic [ADDR_W-1:0] vaddr_t;

    typedef enum logic [2:0] {
        WK_NONE,
        WK_CTRL,
        WK_SCRL_A,
        WK_SCRL_B,
        WK_ADDR_A,
        WK_ADDR_B
    } wr_kind_e;
endpackage

// File: rtl/sau_decode.sv
// Register access decoder: turns a strobe, an offset and the phase bit
// into one write kind, plus a phase-clear pulse for a status read.
// Assumes read and write strobes are never both meant for the same offset.
module sau_decode
    import scroll_pkg::*;
(
    input  logic              wr,
    input  logic              rd,
    input  logic [OFFS_W-1:0] offs,
    input  logic              phase,
    output wr_kind_e          kind,
    output logic              clr_phase
);
    // Classify the current access.
    always_comb begin
        kind = WK_NONE;
        if (wr) begin
            case (offs)
                OFFS_CTRL: kind = WK_CTRL;
                OFFS_SCRL: kind = phase ? WK_SCRL_B : WK_SCRL_A;
                OFFS_ADDR: kind = phase ? WK_ADDR_B : WK_ADDR_A;
                default:   kind = WK_NONE;
            endcase
        end
    end

    // A status read clears the phase bit.
    always_comb clr_phase = rd && !wr && (offs == OFFS_STAT);
endmodule

// File: rtl/sau_timing.sv
// Display timing decode: raises the full-copy and horizontal-copy strobes
// at fixed dots. Assumes that line, dot and pre-render come from the raster counters.
module sau_timing #(
    parameter int LINE_W    = 9,
    parameter int DOT_W     = 9,
    parameter int VIS_LINES = 240,
    parameter int HCOPY_DOT = 257,
    parameter int FCOPY_DOT = 304
) (
    input  logic              render_en,
    input  logic [LINE_W-1:0] scanline,
    input  logic [DOT_W-1:0]  dot,
    input  logic              prerender,
    output logic              full_copy,
    output logic              horiz_copy
);
    localparam logic [LINE_W-1:0] VIS_LIM = LINE_W'(VIS_LINES);
    localparam logic [DOT_W-1:0]  H_DOT   = DOT_W'(HCOPY_DOT);
    localparam logic [DOT_W-1:0]  F_DOT   = DOT_W'(FCOPY_DOT);

    logic line_active;

    // Lines on which the horizontal copy applies.
    always_comb line_active = prerender || (scanline < VIS_LIM);

    // Copy strobes, gated by rendering.
    always_comb begin
        full_copy  = render_en && prerender && (dot == F_DOT);
        horiz_copy = render_en && line_active && (dot == H_DOT);
    end
endmodule

// File: rtl/sau_latch.sv
// Staging latch, fine offset and phase bit. Also presents the latch value
// after this cycle's write (t_next), which the live address uses when a
// second address byte arrives.
module sau_latch
    import scroll_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  wr_kind_e          kind,
    input  logic              clr_phase,
    input  logic [DATA_W-1:0] wdata,
    output vaddr_t            t_q,
    output vaddr_t            t_next,
    output logic [FINE_W-1:0] fine_x,
    output logic              phase
);
    logic [FINE_W-1:0] x_next;

    // Place the write data into the latch fields for each write kind.
    always_comb begin
        t_next = t_q;
        x_next = fine_x;
        case (kind)
            WK_CTRL:   t_next[11:10] = wdata[1:0];
            WK_SCRL_A: begin
                x_next      = wdata[2:0];
                t_next[4:0] = wdata[7:3];
            end
            WK_SCRL_B: begin
                t_next[14:12] = wdata[2:0];
                t_next[9:5]   = wdata[7:3];
            end
            WK_ADDR_A: begin
                t_next[14]   = 1'b0;
                t_next[13:8] = wdata[5:0];
            end
            WK_ADDR_B: t_next[7:0] = wdata;
            default:   ;
        endcase
    end

    // Register the latch, the fine offset and the phase bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q    <= '0;
            fine_x <= '0;
            phase  <= 1'b0;
        end else begin
            t_q    <= t_next;
            fine_x <= x_next;
            if (kind inside {WK_SCRL_A, WK_SCRL_B, WK_ADDR_A, WK_ADDR_B})
                phase <= !phase;
            else if (clr_phase)
                phase <= 1'b0;
        end
    end
endmodule

// File: rtl/sau_vaddr.sv
// Live address register. Priority, highest first: second address byte,
// full-frame copy, per-line horizontal copy. Copies use the latch as it
// was before this cycle's write.
module sau_vaddr
    import scroll_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   load_all,
    input  vaddr_t t_next,
    input  vaddr_t t_q,
    input  logic   full_copy,
    input  logic   horiz_copy,
    output vaddr_t v_q
);
    // Select the next live address and register it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            v_q <= '0;
        else if (load_all)
            v_q <= t_next;
        else if (full_copy)
            v_q <= t_q;
        else if (horiz_copy)
            v_q <= (v_q & ~HORIZ_MASK) | (t_q & HORIZ_MASK);
    end
endmodule

// File: rtl/scroll_addr_unit.sv
// Top level of the scroll and video address unit. It connects the access
// decoder, the raster timing decode, the staging latch and the live address.
module scroll_addr_unit
    import scroll_pkg::*;
#(
    parameter int LINE_W    = 9,
    parameter int DOT_W     = 9,
    parameter int VIS_LINES = 240,
    parameter int HCOPY_DOT = 257,
    parameter int FCOPY_DOT = 304
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [2:0]        cpu_offs,
    input  logic [7:0]        cpu_wdata,
    input  logic              render_en,
    input  logic [LINE_W-1:0] scanline,
    input  logic [DOT_W-1:0]  dot,
    input  logic              prerender,
    output logic [14:0]       vaddr_o,
    output logic [2:0]        fine_x_o
);
    wr_kind_e kind;
    logic     clr_phase;
    logic     tog_w;
    logic     full_copy;
    logic     horiz_copy;
    vaddr_t   t_q;
    vaddr_t   t_next;
    vaddr_t   v_q;

    sau_decode u_dec (
        .wr(cpu_wr), .rd(cpu_rd), .offs(cpu_offs), .phase(tog_w),
        .kind(kind), .clr_phase(clr_phase)
    );

    sau_timing #(
        .LINE_W(LINE_W), .DOT_W(DOT_W), .VIS_LINES(VIS_LINES),
        .HCOPY_DOT(HCOPY_DOT), .FCOPY_DOT(FCOPY_DOT)
    ) u_tim (
        .render_en(render_en), .scanline(scanline), .dot(dot),
        .prerender(prerender), .full_copy(full_copy), .horiz_copy(horiz_copy)
    );

    sau_latch u_lat (
        .clk(clk), .rst_n(rst_n), .kind(kind), .clr_phase(clr_phase),
        .wdata(cpu_wdata), .t_q(t_q), .t_next(t_next),
        .fine_x(fine_x_o), .phase(tog_w)
    );

    sau_vaddr u_v (
        .clk(clk), .rst_n(rst_n), .load_all(kind == WK_ADDR_B),
        .t_next(t_next), .t_q(t_q), .full_copy(full_copy),
        .horiz_copy(horiz_copy), .v_q(v_q)
    );

    // Drive the live address output.
    always_comb vaddr_o = v_q;
endmodule

// File: rtl/sau_checker.sv
// Checker for the scroll/address unit. It watches the ports and the phase bit.
module sau_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cpu_wr,
    input logic       cpu_rd,
    input logic [2:0] cpu_offs,
    input logic [7:0] cpu_wdata,
    input logic       render_en,
    input logic [14:0] vaddr_o,
    input logic [2:0] fine_x_o,
    input logic       tog
);
    a_r2_flip: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr && (cpu_offs == 3'd5 || cpu_offs == 3'd6) |=> tog != $past(tog));

    a_r2_status_clear: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rd && !cpu_wr && cpu_offs == 3'd2 |=> !tog);

    a_r2_ctrl_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr && cpu_offs == 3'd0 |=> $stable(tog));

    a_r3_fine_load: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr && cpu_offs == 3'd5 && !tog |=> fine_x_o == $past(cpu_wdata[2:0]));

    a_r4_scroll_keeps_v: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr && cpu_offs == 3'd5 && !render_en |=> $stable(vaddr_o));

    a_r6_addr_low_load: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr && cpu_offs == 3'd6 && tog |=>
        vaddr_o[7:0] == $past(cpu_wdata) && !vaddr_o[14]);

    a_r10_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !render_en && !(cpu_wr && cpu_offs == 3'd6) |=> $stable(vaddr_o));
endmodule

bind scroll_addr_unit sau_checker u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_offs(cpu_offs), .cpu_wdata(cpu_wdata), .render_en(render_en),
    .vaddr_o(vaddr_o), .fine_x_o(fine_x_o), .tog(tog_w)
);

// File: tb/sim_scroll_addr_unit.sv
module sim_scroll_addr_unit;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_wr = 1'b0, cpu_rd = 1'b0;
    logic [2:0]  cpu_offs = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        render_en = 1'b0;
    logic [8:0]  scanline = '0, dot = '0;
    logic        prerender = 1'b0;
    logic [14:0] vaddr_o;
    logic [2:0]  fine_x_o;

    int checks = 0, fails = 0;
    bit done = 0;

    logic [14:0] mT = '0, mV = '0;
    logic [2:0]  mX = '0;
    logic        mTog = 1'b0;

    logic [14:0] q_v[$];
    logic [2:0]  q_x[$];
    string       q_tag[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    scroll_addr_unit u0 (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
        .cpu_offs(cpu_offs), .cpu_wdata(cpu_wdata), .render_en(render_en),
        .scanline(scanline), .dot(dot), .prerender(prerender),
        .vaddr_o(vaddr_o), .fine_x_o(fine_x_o)
    );

    // Driver: apply one cycle of stimulus, predict the result, queue it.
    task automatic cyc(input logic wr, input logic rd, input logic [2:0] offs,
                       input logic [7:0] d, input logic ren, input logic [8:0] line,
                       input logic [8:0] dt, input logic pre, input string tag);
        logic [14:0] tn, vn;
        logic [2:0]  xn;
        logic        tg;
        cpu_wr = wr; cpu_rd = rd; cpu_offs = offs; cpu_wdata = d;
        render_en = ren; scanline = line; dot = dt; prerender = pre;
        tn = mT; vn = mV; xn = mX; tg = mTog;
        if (ren && pre && dt == 9'd304) vn = mT;
        else if (ren && (pre || line < 9'd240) && dt == 9'd257) begin
            vn[10] = mT[10]; vn[4:0] = mT[4:0];
        end
        if (wr) begin
            case (offs)
                3'd0: tn[11:10] = d[1:0];
                3'd5: begin
                    if (!mTog) begin xn = d[2:0]; tn[4:0] = d[7:3]; end
                    else begin tn[14:12] = d[2:0]; tn[9:5] = d[7:3]; end
                    tg = !mTog;
                end
                3'd6: begin
                    if (!mTog) begin tn[14] = 1'b0; tn[13:8] = d[5:0]; end
                    else begin tn[7:0] = d; vn = tn; end
                    tg = !mTog;
                end
                default: ;
            endcase
        end else if (rd && offs == 3'd2) tg = 1'b0;
        mT = tn; mV = vn; mX = xn; mTog = tg;
        q_v.push_back(vn); q_x.push_back(xn); q_tag.push_back(tag);
        @(negedge clk);
    endtask

    task automatic idle(input string tag);
        cyc(0, 0, 3'd1, 8'h00, 0, 9'd0, 9'd0, 0, tag);
    endtask

    // Monitor: after each rising edge, compare outputs with the queued prediction.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q_v.size() > 0) begin
                logic [14:0] ev;
                logic [2:0]  ex;
                string       tg;
                ev = q_v.pop_front(); ex = q_x.pop_front(); tg = q_tag.pop_front();
                checks++;
                if (vaddr_o !== ev || fine_x_o !== ex) begin
                    fails++;
                    $display("FAIL %s: vaddr=%h fine_x=%0d expected vaddr=%h fine_x=%0d",
                             tg, vaddr_o, fine_x_o, ev, ex);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        checks++;
        if (vaddr_o !== 15'h0 || fine_x_o !== 3'h0) begin
            fails++;
            $display("FAIL R1: vaddr=%h fine_x=%0d expected 0 0", vaddr_o, fine_x_o);
        end
        idle("R1 idle");
        // R3 / R4: scroll pair, rendering off, live address untouched
        cyc(1, 0, 3'd5, 8'h7D, 0, 9'd0, 9'd0, 0, "R3 first scroll");
        cyc(1, 0, 3'd5, 8'hAE, 0, 9'd0, 9'd0, 0, "R4 second scroll");
        // R7: page select
        cyc(1, 0, 3'd0, 8'hFE, 0, 9'd0, 9'd0, 0, "R7 control write");
        cyc(1, 0, 3'd0, 8'h03, 0, 9'd0, 9'd0, 0, "R7 control write");
        // R8: full copy brings the latch out
        cyc(0, 0, 3'd1, 8'h00, 1, 9'd261, 9'd303, 1, "R8 dot before copy");
        cyc(0, 0, 3'd1, 8'h00, 1, 9'd261, 9'd304, 1, "R8 full copy");
        // R5 / R6: address pair, top data bits ignored
        cyc(1, 0, 3'd6, 8'hFF, 0, 9'd0, 9'd0, 0, "R5 first address");
        cyc(1, 0, 3'd6, 8'h5A, 0, 9'd0, 9'd0, 0, "R6 second address");
        cyc(1, 0, 3'd6, 8'hC1, 0, 9'd0, 9'd0, 0, "R5 first address");
        cyc(1, 0, 3'd6, 8'h23, 0, 9'd0, 9'd0, 0, "R6 second address");
        // R2: status read clears the phase between scroll bytes
        cyc(1, 0, 3'd5, 8'h11, 0, 9'd0, 9'd0, 0, "R2 scroll then read");
        cyc(0, 1, 3'd2, 8'h00, 0, 9'd0, 9'd0, 0, "R2 status read");
        cyc(1, 0, 3'd5, 8'h16, 0, 9'd0, 9'd0, 0, "R2 scroll after read is first");
        cyc(1, 0, 3'd5, 8'h3B, 0, 9'd0, 9'd0, 0, "R2 second scroll");
        // R2: control write does not move the phase
        cyc(1, 0, 3'd6, 8'h12, 0, 9'd0, 9'd0, 0, "R2 addr first");
        cyc(1, 0, 3'd0, 8'h02, 0, 9'd0, 9'd0, 0, "R2 control between");
        cyc(1, 0, 3'd6, 8'h34, 0, 9'd0, 9'd0, 0, "R2 addr second");
        // R2: status read not at offset 2 is ignored
        cyc(1, 0, 3'd5, 8'hF8, 0, 9'd0, 9'd0, 0, "R2 scroll first");
        cyc(0, 1, 3'd3, 8'h00, 0, 9'd0, 9'd0, 0, "R2 read other offset");
        cyc(1, 0, 3'd5, 8'h07, 0, 9'd0, 9'd0, 0, "R2 scroll second");
        // R9: horizontal copy on a visible line and on the pre-render line
        cyc(1, 0, 3'd5, 8'hA9, 0, 9'd0, 9'd0, 0, "R9 set coarse x");
        cyc(1, 0, 3'd5, 8'h00, 0, 9'd0, 9'd0, 0, "R9 finish pair");
        cyc(1, 0, 3'd0, 8'h01, 0, 9'd0, 9'd0, 0, "R9 page select");
        cyc(0, 0, 3'd1, 8'h00, 1, 9'd100, 9'd257, 0, "R9 visible line copy");
        cyc(1, 0, 3'd5, 8'h50, 0, 9'd0, 9'd0, 0, "R9 set coarse x");
        cyc(1, 0, 3'd5, 8'hFF, 0, 9'd0, 9'd0, 0, "R9 finish pair");
        cyc(1, 0, 3'd0, 8'h00, 0, 9'd0, 9'd0, 0, "R9 page select");
        cyc(0, 0, 3'd1, 8'h00, 1, 9'd261, 9'd257, 1, "R9 pre-render copy");
        cyc(0, 0, 3'd1, 8'h00, 1, 9'd239, 9'd256, 0, "R9 off dot");
        // R10: no copy when disabled or on other lines
        cyc(1, 0, 3'd5, 8'hFF, 0, 9'd0, 9'd0, 0, "R10 set latch");
        cyc(1, 0, 3'd5, 8'hFF, 0, 9'd0, 9'd0, 0, "R10 set latch");
        cyc(0, 0, 3'd1, 8'h00, 0, 9'd10, 9'd257, 0, "R10 disabled horiz");
        cyc(0, 0, 3'd1, 8'h00, 0, 9'd261, 9'd304, 1, "R10 disabled full");
        cyc(0, 0, 3'd1, 8'h00, 1, 9'd245, 9'd257, 0, "R10 blank line");
        cyc(0, 0, 3'd1, 8'h00, 1, 9'd100, 9'd304, 0, "R10 full on visible line");
        // R11: address byte wins over full copy
        cyc(1, 0, 3'd6, 8'h0A, 0, 9'd0, 9'd0, 0, "R11 addr first");
        cyc(1, 0, 3'd6, 8'hB7, 1, 9'd261, 9'd304, 1, "R11 addr over full copy");
        // R11: copy uses the latch before a same-cycle control write
        cyc(1, 0, 3'd0, 8'h00, 0, 9'd0, 9'd0, 0, "R11 clear page");
        cyc(1, 0, 3'd0, 8'h03, 1, 9'd50, 9'd257, 0, "R11 control during copy");
        cyc(0, 0, 3'd1, 8'h00, 1, 9'd51, 9'd257, 0, "R11 next line copy");
        cyc(1, 0, 3'd5, 8'hE8, 1, 9'd261, 9'd304, 1, "R11 scroll during full copy");
        cyc(0, 0, 3'd1, 8'h00, 1, 9'd261, 9'd304, 1, "R11 full copy after");
        idle("idle");
        idle("idle");
        repeat (2) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule